// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Condition Flags

This block is the arithmetic and logic datapath of a small multicycle processor, together with the condition-flag register that the processor keeps between instructions. For each executed instruction the sequencer presents the destination register value, a second operand, and the instruction's operation selector. The second operand is either a register value or an immediate. The selector is either the function nibble of a register-register instruction or the major opcode of an immediate instruction. The unit returns the combinational result, a writeback strobe, and the next zero, carry, sign and overflow flags. The flags are captured in a register on the clock edge that ends the execute step.

The registered flags drive a branch evaluator. The sequencer gives it the major opcode of a jump instruction and gets back whether the jump is taken, covering equal, not-equal, unsigned below, unsigned above-or-equal and signed less. The flag register can also be read as a packed byte and reloaded from a byte, which is how flags are pushed to and popped from the stack. Compare instructions set the flags without producing a writeback.

Top module: `alu_flag_unit`

## Requirements
- R1: With `use_imm`=0, `func_sel` picks the operation on A=`rd_val` and B=`rr_val`: 0000 result B, 0001 A+B, 0010 A-B, 0011 A AND B, 0100 A OR B, 0101 A XOR B. When `op_valid`=1, `wr_en` is 1 for each of these.
- R2: With `use_imm`=1, `imm_opc` picks the operation with B=`imm_val`: 0001 compare, 0010 add, 0011 subtract, 0100 AND, 0101 OR, 0110 XOR, 0111 result B. `rr_val` has no effect in this case.
- R3: A compare (`func_sel`=1111 for register-register, `imm_opc`=0001 for immediate) computes A-B and updates the flags. It keeps `wr_en` at 0.
- R4: Add sets C to the carry out of bit 7. Subtract and compare set C to 1 exactly when A < B unsigned (borrow). In both cases V is the two's-complement overflow of the signed operation.
- R5: For every operation, Z is 1 exactly when the 8-bit result is zero and N equals result bit 7. The logic operations and the move clear both C and V.
- R6: The shifts act on B by one bit. 1100 is a logical right shift with a 0 fill, 1101 is a left shift with a 0 fill, and 1110 is an arithmetic right shift that keeps bit 7. C takes the bit shifted out and V is cleared.
- R7: The flags change only on a clock edge with `op_valid`=1 and a decodable selector, or with `flags_load`=1. The register-register codes 0110 to 1011 and the immediate opcodes 0000 and 1000 to 1111 leave the flags unchanged and keep `wr_en` at 0.
- R8: `flags_byte` is {4'b0000, V, N, C, Z}, with Z in bit 0. `flags_load`=1 loads the flags from bits 3:0 of `flags_in` on the next edge and ignores bits 7:4. A load takes priority over an operation in the same cycle.
- R9: `br_taken` is computed from the registered flags for `jmp_opc`: 1000 always, 1011 Z, 1100 not Z, 1101 C, 1110 not C, 1111 N XOR V. Any other code gives 0.
- R10: While `rst_n` is low, all four flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_valid | input | 1 | Execute strobe: this cycle carries an operation |
| use_imm | input | 1 | 1 selects the immediate form |
| func_sel | input | 4 | Function nibble of a register-register instruction |
| imm_opc | input | 4 | Major opcode of an immediate instruction |
| rd_val | input | 8 | Destination register value (operand A) |
| rr_val | input | 8 | Source register value (operand B, register form) |
| imm_val | input | 8 | Immediate value (operand B, immediate form) |
| flags_load | input | 1 | Load the flags from `flags_in` |
| flags_in | input | 8 | Byte popped from the stack |
| jmp_opc | input | 4 | Major opcode of a jump instruction |
| result | output | 8 | Operation result |
| wr_en | output | 1 | Writeback strobe for the destination register |
| flags_byte | output | 8 | Packed registered flags |
| br_taken | output | 1 | Branch condition outcome |

## Verification
The stimulus targets the boundaries of the flag logic. These include 0x7F+1 and 0x80-1, where a wrong overflow formula leaves V clear, and 0xFF+1 and 0-1, where an inverted borrow flips C and with it the JB and JAE outcomes. A sign-mixed case makes signed-less and unsigned-below disagree, so a branch that reads C in place of N XOR V is caught. Compares are checked for a missing writeback strobe. The non-ALU function codes and the undecodable immediate opcodes are checked for leaving the flags untouched, and a design that decoded them as operations would show changed flags in the packed byte. A restore issued together with an operation, and a restore whose upper nibble is nonzero, expose a wrong priority and a wrong packing.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_MOV = 4'b0000,
      OP_ADD = 4'b0001,
      OP_SUB = 4'b0010,
      OP_AND = 4'b0011,
      OP_OR  = 4'b0100,
      OP_XOR = 4'b0101,
      OP_LSR = 4'b1100,
      OP_LSL = 4'b1101,
      OP_ASR = 4'b1110,
      OP_CMP = 4'b1111
   } alu_op_e;

   typedef struct packed {
      logic    legal;
      logic    wback;
      alu_op_e op;
   } alu_ctrl_t;

   // Field order matches the packed byte: V N C Z (Z in bit 0)
   typedef struct packed {
      logic v;
      logic n;
      logic c;
      logic z;
   } cond_flags_t;

   localparam int FLAG_BITS = 4;

   localparam logic [3:0] JOP_ALWAYS = 4'b1000;
   localparam logic [3:0] JOP_EQ     = 4'b1011;
   localparam logic [3:0] JOP_NE     = 4'b1100;
   localparam logic [3:0] JOP_BELOW  = 4'b1101;
   localparam logic [3:0] JOP_AE     = 4'b1110;
   localparam logic [3:0] JOP_LESS   = 4'b1111;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu_pkg::*;
(
   input  logic       use_imm,
   input  logic [3:0] func_sel,
   input  logic [3:0] imm_opc,
   output alu_ctrl_t  ctrl
);

   alu_ctrl_t reg_ctrl;
   alu_ctrl_t imm_ctrl;

   always_comb begin
      reg_ctrl = '{legal: 1'b1, wback: 1'b1, op: alu_op_e'(func_sel)};
      unique case (func_sel)
         4'b0110, 4'b0111, 4'b1000,
         4'b1001, 4'b1010, 4'b1011: begin
            reg_ctrl.legal = 1'b0;
            reg_ctrl.wback = 1'b0;
            reg_ctrl.op    = OP_MOV;
         end
         4'b1111: reg_ctrl.wback = 1'b0;
         default: ;
      endcase
   end

   always_comb begin
      imm_ctrl = '{legal: 1'b1, wback: 1'b1, op: OP_MOV};
      unique case (imm_opc)
         4'b0001: begin
            imm_ctrl.op    = OP_CMP;
            imm_ctrl.wback = 1'b0;
         end
         4'b0010: imm_ctrl.op = OP_ADD;
         4'b0011: imm_ctrl.op = OP_SUB;
         4'b0100: imm_ctrl.op = OP_AND;
         4'b0101: imm_ctrl.op = OP_OR;
         4'b0110: imm_ctrl.op = OP_XOR;
         4'b0111: imm_ctrl.op = OP_MOV;
         default: begin
            imm_ctrl.legal = 1'b0;
            imm_ctrl.wback = 1'b0;
         end
      endcase
   end

   assign ctrl = use_imm ? imm_ctrl : reg_ctrl;

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit CARRY_CHAIN = 1'b1
) (
   input  alu_op_e           op,
   input  logic [WIDTH-1:0]  opa,
   input  logic [WIDTH-1:0]  opb,
   output logic [WIDTH-1:0]  res,
   output cond_flags_t       flags
);

   localparam int MSB = WIDTH - 1;

   logic             subtract;
   logic [WIDTH-1:0] b_adj;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;

   assign subtract = (op == OP_SUB) || (op == OP_CMP);
   assign b_adj    = subtract ? ~opb : opb;

   generate
      if (CARRY_CHAIN) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = subtract;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = opa[i] ^ b_adj[i] ^ cy[i];
            assign cy[i+1] = (opa[i] & b_adj[i]) | (cy[i] & (opa[i] ^ b_adj[i]));
         end
         assign cout = cy[WIDTH];
         assign ovf  = cy[WIDTH] ^ cy[WIDTH-1];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, opa} + {1'b0, b_adj} + {{WIDTH{1'b0}}, subtract};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
         assign ovf  = (opa[MSB] == b_adj[MSB]) && (sum[MSB] != opa[MSB]);
      end
   endgenerate

   logic carry_q;
   logic ovf_q;

   always_comb begin
      res     = opb;
      carry_q = 1'b0;
      ovf_q   = 1'b0;
      unique case (op)
         OP_MOV: res = opb;
         OP_ADD: begin
            res     = sum;
            carry_q = cout;
            ovf_q   = ovf;
         end
         OP_SUB, OP_CMP: begin
            res     = sum;
            carry_q = ~cout;
            ovf_q   = ovf;
         end
         OP_AND: res = opa & opb;
         OP_OR:  res = opa | opb;
         OP_XOR: res = opa ^ opb;
         OP_LSR: begin
            res     = {1'b0, opb[MSB:1]};
            carry_q = opb[0];
         end
         OP_LSL: begin
            res     = {opb[MSB-1:0], 1'b0};
            carry_q = opb[MSB];
         end
         OP_ASR: begin
            res     = {opb[MSB], opb[MSB:1]};
            carry_q = opb[0];
         end
         default: ;
      endcase
   end

   assign flags.z = (res == '0);
   assign flags.n = res[MSB];
   assign flags.c = carry_q;
   assign flags.v = ovf_q;

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  cond_flags_t       upd_flags,
   input  logic              load_en,
   input  logic [WIDTH-1:0]  load_byte,
   output cond_flags_t       flags_q,
   output logic [WIDTH-1:0]  packed_byte
);

   localparam int PAD = WIDTH - FLAG_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (load_en) begin
         flags_q <= cond_flags_t'(load_byte[FLAG_BITS-1:0]);
      end else if (upd_en) begin
         flags_q <= upd_flags;
      end
   end

   generate
      if (PAD > 0) begin : g_pad
         assign packed_byte = {{PAD{1'b0}}, flags_q};
      end else begin : g_nopad
         assign packed_byte = flags_q;
      end
   endgenerate

endmodule

// File: rtl/alu_branch_eval.sv
module alu_branch_eval
   import alu_pkg::*;
(
   input  logic [3:0]   jmp_opc,
   input  cond_flags_t  flags,
   output logic         taken
);

   always_comb begin
      unique case (jmp_opc)
         JOP_ALWAYS: taken = 1'b1;
         JOP_EQ:     taken = flags.z;
         JOP_NE:     taken = ~flags.z;
         JOP_BELOW:  taken = flags.c;
         JOP_AE:     taken = ~flags.c;
         JOP_LESS:   taken = flags.n ^ flags.v;
         default:    taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit CARRY_CHAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              use_imm,
   input  logic [3:0]        func_sel,
   input  logic [3:0]        imm_opc,
   input  logic [WIDTH-1:0]  rd_val,
   input  logic [WIDTH-1:0]  rr_val,
   input  logic [WIDTH-1:0]  imm_val,
   input  logic              flags_load,
   input  logic [WIDTH-1:0]  flags_in,
   input  logic [3:0]        jmp_opc,
   output logic [WIDTH-1:0]  result,
   output logic              wr_en,
   output logic [WIDTH-1:0]  flags_byte,
   output logic              br_taken
);

   generate
      if (WIDTH < FLAG_BITS) begin : g_width_chk
         $error("alu_flag_unit: WIDTH must hold the packed flag byte");
      end
   endgenerate

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] opb;
   cond_flags_t      next_flags;
   cond_flags_t      cur_flags;

   assign opb = use_imm ? imm_val : rr_val;

   alu_op_decode u_dec (
      .use_imm  (use_imm),
      .func_sel (func_sel),
      .imm_opc  (imm_opc),
      .ctrl     (ctrl)
   );

   alu_core #(.WIDTH(WIDTH), .CARRY_CHAIN(CARRY_CHAIN)) u_core (
      .op    (ctrl.op),
      .opa   (rd_val),
      .opb   (opb),
      .res   (result),
      .flags (next_flags)
   );

   alu_flag_reg #(.WIDTH(WIDTH)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en      (op_valid && ctrl.legal),
      .upd_flags   (next_flags),
      .load_en     (flags_load),
      .load_byte   (flags_in),
      .flags_q     (cur_flags),
      .packed_byte (flags_byte)
   );

   alu_branch_eval u_br (
      .jmp_opc (jmp_opc),
      .flags   (cur_flags),
      .taken   (br_taken)
   );

   assign wr_en = op_valid && ctrl.legal && ctrl.wback;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              use_imm,
   input logic [3:0]        func_sel,
   input logic [3:0]        imm_opc,
   input logic              flags_load,
   input logic [WIDTH-1:0]  flags_in,
   input logic [3:0]        jmp_opc,
   input logic              wr_en,
   input logic [WIDTH-1:0]  flags_byte,
   input logic              br_taken
);

   logic is_cmp;
   logic is_logic;
   assign is_cmp   = use_imm ? (imm_opc == 4'b0001) : (func_sel == 4'b1111);
   assign is_logic = use_imm ? (imm_opc inside {4'b0100, 4'b0101, 4'b0110, 4'b0111})
                             : (func_sel inside {4'b0000, 4'b0011, 4'b0100, 4'b0101});

   // R3: compare never writes back
   assert_cmp_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmp |-> !wr_en);

   // R5: logic ops and move leave C and V clear
   assert_logic_clears_cv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_logic && !flags_load) |=> (flags_byte[3] == 1'b0 && flags_byte[1] == 1'b0));

   // R7: no strobe, no flag change
   assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !flags_load) |=> $stable(flags_byte));

   // R8: restore loads the low nibble
   assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flags_load |=> (flags_byte == {{(WIDTH-4){1'b0}}, $past(flags_in[3:0])}));

   // R8: upper bits of the packed byte stay zero
   assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flags_byte[WIDTH-1:4] == '0);

   // R9: equal branch follows Z
   assert_eq_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_opc == 4'b1011) |-> (br_taken == flags_byte[0]));

   // R9: above-or-equal follows not C
   assert_ae_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_opc == 4'b1110) |-> (br_taken == !flags_byte[1]));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .use_imm    (use_imm),
   .func_sel   (func_sel),
   .imm_opc    (imm_opc),
   .flags_load (flags_load),
   .flags_in   (flags_in),
   .jmp_opc    (jmp_opc),
   .wr_en      (wr_en),
   .flags_byte (flags_byte),
   .br_taken   (br_taken)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic       use_imm = 1'b0;
   logic [3:0] func_sel = '0;
   logic [3:0] imm_opc = '0;
   logic [7:0] rd_val = '0;
   logic [7:0] rr_val = '0;
   logic [7:0] imm_val = '0;
   logic       flags_load = 1'b0;
   logic [7:0] flags_in = '0;
   logic [3:0] jmp_opc = '0;
   logic [7:0] result;
   logic       wr_en;
   logic [7:0] flags_byte;
   logic       br_taken;

   always #2 clk = ~clk;

   alu_flag_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .use_imm(use_imm),
      .func_sel(func_sel), .imm_opc(imm_opc), .rd_val(rd_val), .rr_val(rr_val),
      .imm_val(imm_val), .flags_load(flags_load), .flags_in(flags_in),
      .jmp_opc(jmp_opc), .result(result), .wr_en(wr_en),
      .flags_byte(flags_byte), .br_taken(br_taken)
   );

   typedef struct {
      string      req;
      bit         chk_res;
      logic [7:0] res;
      logic       wr;
      logic [7:0] fb;
      logic       br;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [3:0] mflags = 4'h0;   // model {V,N,C,Z}

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic br_model(input logic [3:0] jop, input logic [3:0] f);
      case (jop)
         4'b1000: return 1'b1;
         4'b1011: return f[0];
         4'b1100: return !f[0];
         4'b1101: return f[1];
         4'b1110: return !f[1];
         4'b1111: return f[2] ^ f[3];
         default: return 1'b0;
      endcase
   endfunction

   task automatic drive(input string req, input bit imm, input logic [3:0] code,
                        input logic [7:0] a, input logic [7:0] b, input bit valid,
                        input bit load, input logic [7:0] fin, input logic [3:0] jop);
      logic [3:0] op;
      bit         ok;
      bit         wb;
      logic [7:0] r;
      logic       c;
      logic       v;
      item_t      it;
      ok = 1'b1;
      wb = 1'b1;
      op = code;
      if (imm) begin
         case (code)
            4'h1: begin op = 4'hF; end
            4'h2: op = 4'h1;
            4'h3: op = 4'h2;
            4'h4: op = 4'h3;
            4'h5: op = 4'h4;
            4'h6: op = 4'h5;
            4'h7: op = 4'h0;
            default: ok = 1'b0;
         endcase
      end else if (code >= 4'h6 && code <= 4'hB) begin
         ok = 1'b0;
      end
      if (op == 4'hF) wb = 1'b0;
      r = 8'h00; c = 1'b0; v = 1'b0;
      case (op)
         4'h0: r = b;
         4'h1: begin {c, r} = {1'b0, a} + {1'b0, b}; v = (a[7] == b[7]) && (r[7] != a[7]); end
         4'h2, 4'hF: begin r = a - b; c = (a < b); v = (a[7] != b[7]) && (r[7] != a[7]); end
         4'h3: r = a & b;
         4'h4: r = a | b;
         4'h5: r = a ^ b;
         4'hC: begin r = b >> 1; c = b[0]; end
         4'hD: begin r = b << 1; c = b[7]; end
         4'hE: begin r = {b[7], b[7:1]}; c = b[0]; end
         default: ;
      endcase
      if (load) mflags = fin[3:0];
      else if (valid && ok) mflags = {v, r[7], c, (r == 8'h00)};
      @(negedge clk);
      op_valid   = valid;
      use_imm    = imm;
      func_sel   = imm ? 4'h0 : code;
      imm_opc    = imm ? code : 4'h0;
      rd_val     = a;
      rr_val     = imm ? ~b : b;
      imm_val    = imm ? b : ~b;
      flags_load = load;
      flags_in   = fin;
      jmp_opc    = jop;
      it.req     = req;
      it.chk_res = valid && ok && wb;
      it.res     = r;
      it.wr      = valid && ok && wb;
      it.fb      = {4'h0, mflags};
      it.br      = br_model(jop, mflags);
      q.push_back(it);
   endtask

   // monitor: compare after each edge, away from it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.chk_res) chk(it.req, "result", result, it.res);
            chk(it.req, "wr_en", {7'h0, wr_en}, {7'h0, it.wr});
            chk(it.req, "flags_byte", flags_byte, it.fb);
            chk(it.req, "br_taken", {7'h0, br_taken}, {7'h0, it.br});
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: flags cleared after reset; JNE taken
      drive("R10", 0, 4'h0, 8'h00, 8'h00, 0, 0, 8'h00, 4'b1100);
      // R1 register-form operations
      drive("R1", 0, 4'h0, 8'h12, 8'h80, 1, 0, 8'h00, 4'b1111);
      drive("R1", 0, 4'h1, 8'h21, 8'h13, 1, 0, 8'h00, 4'b1011);
      drive("R1", 0, 4'h3, 8'hF0, 8'h3C, 1, 0, 8'h00, 4'b1011);
      drive("R1", 0, 4'h4, 8'h00, 8'h00, 1, 0, 8'h00, 4'b1011);
      drive("R1", 0, 4'h5, 8'hA5, 8'hFF, 1, 0, 8'h00, 4'b1100);
      // R4 carry and overflow boundaries
      drive("R4", 0, 4'h1, 8'h7F, 8'h01, 1, 0, 8'h00, 4'b1111);
      drive("R4", 0, 4'h1, 8'hFF, 8'h01, 1, 0, 8'h00, 4'b1101);
      drive("R4", 0, 4'h2, 8'h00, 8'h01, 1, 0, 8'h00, 4'b1101);
      drive("R4", 0, 4'h2, 8'h80, 8'h01, 1, 0, 8'h00, 4'b1111);
      drive("R4", 0, 4'h2, 8'h05, 8'h05, 1, 0, 8'h00, 4'b1110);
      // R5 logic after a carry clears C and V
      drive("R4", 0, 4'h1, 8'h80, 8'h80, 1, 0, 8'h00, 4'b1101);
      drive("R5", 0, 4'h3, 8'h80, 8'h80, 1, 0, 8'h00, 4'b1110);
      // R6 shifts
      drive("R6", 0, 4'hC, 8'h00, 8'h81, 1, 0, 8'h00, 4'b1101);
      drive("R6", 0, 4'hD, 8'h00, 8'h81, 1, 0, 8'h00, 4'b1101);
      drive("R6", 0, 4'hE, 8'h00, 8'h81, 1, 0, 8'h00, 4'b1111);
      drive("R6", 0, 4'hC, 8'h00, 8'h01, 1, 0, 8'h00, 4'b1011);
      // R3 compares: signed vs unsigned disagreement
      drive("R3", 0, 4'hF, 8'h01, 8'hFF, 1, 0, 8'h00, 4'b1101);
      drive("R3", 0, 4'hF, 8'h01, 8'hFF, 1, 0, 8'h00, 4'b1111);
      drive("R3", 1, 4'h1, 8'h42, 8'h42, 1, 0, 8'h00, 4'b1011);
      // R2 immediate forms
      drive("R2", 1, 4'h2, 8'h10, 8'h05, 1, 0, 8'h00, 4'b1100);
      drive("R2", 1, 4'h3, 8'h10, 8'h20, 1, 0, 8'h00, 4'b1101);
      drive("R2", 1, 4'h4, 8'hCC, 8'h0F, 1, 0, 8'h00, 4'b1011);
      drive("R2", 1, 4'h5, 8'h01, 8'h80, 1, 0, 8'h00, 4'b1111);
      drive("R2", 1, 4'h6, 8'h3C, 8'h3C, 1, 0, 8'h00, 4'b1011);
      drive("R2", 1, 4'h7, 8'h99, 8'h7E, 1, 0, 8'h00, 4'b1100);
      // R7 non-ALU codes and missing strobe leave flags alone
      drive("R4", 0, 4'h2, 8'h00, 8'h01, 1, 0, 8'h00, 4'b1101);
      drive("R7", 0, 4'h7, 8'h00, 8'h00, 1, 0, 8'h00, 4'b1101);
      drive("R7", 0, 4'hA, 8'h00, 8'h00, 1, 0, 8'h00, 4'b1111);
      drive("R7", 1, 4'h0, 8'h00, 8'h00, 1, 0, 8'h00, 4'b1011);
      drive("R7", 1, 4'h9, 8'h00, 8'h00, 1, 0, 8'h00, 4'b1011);
      drive("R7", 0, 4'h4, 8'h00, 8'h00, 0, 0, 8'h00, 4'b1100);
      // R8 restore, upper nibble ignored, priority over operation
      drive("R8", 0, 4'h0, 8'h00, 8'h00, 0, 1, 8'hFA, 4'b1110);
      drive("R8", 0, 4'h0, 8'h00, 8'h00, 0, 1, 8'h05, 4'b1111);
      drive("R8", 0, 4'h1, 8'h7F, 8'h01, 1, 1, 8'h01, 4'b1011);
      // R9 branch codes
      drive("R9", 0, 4'h0, 8'h00, 8'h00, 0, 1, 8'h08, 4'b1111);
      drive("R9", 0, 4'h0, 8'h00, 8'h00, 0, 0, 8'h00, 4'b1000);
      drive("R9", 0, 4'h0, 8'h00, 8'h00, 0, 0, 8'h00, 4'b0011);
      drive("R9", 0, 4'h0, 8'h00, 8'h00, 0, 1, 8'h0C, 4'b1111);
      drive("R9", 0, 4'h0, 8'h00, 8'h00, 0, 0, 8'h00, 4'b1110);
      // R10: reset mid-run clears flags
      drive("R8", 0, 4'h0, 8'h00, 8'h00, 0, 1, 8'h0F, 4'b1011);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      mflags = 4'h0;
      flags_load = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive("R10", 0, 4'h0, 8'h00, 8'h00, 0, 0, 8'h00, 4'b1100);
      drive("R10", 0, 4'h0, 8'h00, 8'h00, 0, 0, 8'h00, 4'b1011);
      repeat (4) @(posedge clk);
      #1;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule